// File: doc/BRIEF.md
# I/O Port Permission Checker

This block rules on whether an I/O-sensitive operation issued by the current context may go ahead. Such operations are port reads and writes (single or string forms, which the block treats alike) and the two operations that clear or set the interrupt-enable flag. A request carries the operation, the current privilege level (CPL), the I/O privilege level field (IOPL), a byte port address and an access size of 1, 2 or 4 bytes. It also carries the base address and the limit of the running task's state structure.

When CPL does not exceed IOPL, the block grants the request at once. When it does, flag operations are refused outright. Port operations instead fall back to the task's own permission bitmap. The block reads the bitmap's 16-bit location from the task structure through a byte-wide memory read port. It then fetches the one or two bitmap bytes that cover every byte port the access touches.

The verdict is a single-cycle pulse that carries either an allow or a general-protection fault. Any offset that lies past the structure limit counts as a refusal.

Top module: `iop_perm_check`

## Requirements
- R1: After reset, `resp_valid`, `resp_allow`, `resp_fault` and `mem_rd_en` are all low.
- R2: Operation code 2'b00 is a port read and 2'b01 is a port write. Code 2'b10 clears the interrupt flag and 2'b11 sets it. For any code, if CPL <= IOPL, a request accepted at a clock edge gets `resp_valid` with `resp_allow` high in the cycle that edge starts, and no memory read is made.
- R3: A flag operation (code bit 1 set) with CPL > IOPL gets `resp_fault` in the cycle after acceptance, with no memory read.
- R4: A port operation with CPL > IOPL first reads the bitmap offset as a 16-bit little-endian value. The low byte comes from `task_base`+102 and the high byte from `task_base`+103. A lookup makes 3 reads when one bitmap byte suffices and 4 when two are needed.
- R5: Port p is governed by bit p mod 8 of the bitmap byte at `task_base` + offset + floor(p/8). A 0 bit permits and a 1 bit denies. Size code 2'b00 covers 1 byte, 2'b01 covers 2 bytes and 2'b10 or 2'b11 covers 4 bytes. The access is allowed only if every covered port p..p+n-1 has a 0 bit.
- R6: When the covered ports cross a bitmap byte boundary, both bitmap bytes are read, and a 1 bit in either one denies.
- R7: If `task_limit` < 103, a port lookup faults in the cycle after acceptance with no reads. After the offset is read, if any needed bitmap byte offset (offset + byte index) is greater than `task_limit`, the request faults with no bitmap read.
- R8: Every verdict is a one-cycle `resp_valid` pulse with exactly one of `resp_allow` / `resp_fault` high. Both are low whenever `resp_valid` is low.
- R9: `mem_rd_en` stays high with a stable `mem_rd_addr` until `mem_rvalid` returns the byte. Any read latency is accepted.
- R10: A request presented while a lookup is in progress is ignored: it produces no verdict of its own and does not change the verdict in flight.
- R11: The request fields, task base and limit are captured at acceptance. Changing `task_base` during a lookup does not change which bitmap is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Operation code (see R2) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level field |
| req_port | input | PORT_W | Byte port address |
| req_size | input | 2 | Access size code (see R5) |
| task_base | input | ADDR_W | Start address of the task state structure |
| task_limit | input | 16 | Highest valid byte offset in the structure |
| mem_rd_en | output | 1 | Memory read request, held until served |
| mem_rd_addr | output | ADDR_W | Byte address to read |
| mem_rdata | input | 8 | Returned byte |
| mem_rvalid | input | 1 | Returned byte is valid this cycle |
| resp_valid | output | 1 | Verdict pulse |
| resp_allow | output | 1 | Operation permitted |
| resp_fault | output | 1 | General-protection fault |

## Verification
The bench builds the block with a 12-bit address and a 6-bit port, so the bitmap spans only nine bytes. This makes it practical to sweep every port address against every size code. That sweep covers every in-byte bit position and every case that crosses a byte boundary, with the memory latency varied between 0 and 2 cycles. A full sweep of CPL, IOPL and operation code covers the direct grant and refusal paths. Limits one below and exactly at each needed bitmap byte offset probe the boundary compare.

// File: rtl/iop_pkg.sv
package iop_pkg;

    localparam int PRIV_W        = 2;
    localparam int LIM_W         = 16;
    localparam int OFF_W         = LIM_W + 1;
    localparam int MAP_FIELD_OFF = 102;

    typedef enum logic [1:0] {
        OP_PORT_RD  = 2'b00,
        OP_PORT_WR  = 2'b01,
        OP_FLAG_CLR = 2'b10,
        OP_FLAG_SET = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE_LO,
        ST_BASE_HI,
        ST_MAP_CHK,
        ST_MAP0,
        ST_MAP1
    } st_e;

    typedef struct packed {
        logic valid;
        logic allow;
        logic fault;
    } verdict_t;

    function automatic logic is_flag_op(op_e op);
        return op[1];
    endfunction

    // one lane per byte port covered by the access
    function automatic logic [3:0] size_lanes(logic [1:0] code);
        case (code)
            2'b00:   return 4'b0001;
            2'b01:   return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/iop_priv_gate.sv
module iop_priv_gate
    import iop_pkg::*;
(
    input  op_e               op,
    input  logic [PRIV_W-1:0] cpl,
    input  logic [PRIV_W-1:0] iopl,
    input  logic [LIM_W-1:0]  limit,
    output logic              direct_done,
    output logic              direct_allow
);
    logic priv_ok;
    logic field_unreachable;

    always_comb begin
        priv_ok           = (cpl <= iopl);
        field_unreachable = (limit < LIM_W'(MAP_FIELD_OFF + 1));
        direct_done       = priv_ok | is_flag_op(op) | field_unreachable;
        direct_allow      = priv_ok;
    end
endmodule

// File: rtl/iop_span_calc.sv
module iop_span_calc
    import iop_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size_code,
    input  logic [15:0]       map_base,
    input  logic [LIM_W-1:0]  limit,
    output logic [15:0]       mask,
    output logic              need_hi,
    output logic [OFF_W-1:0]  off0,
    output logic [OFF_W-1:0]  off1,
    output logic              beyond
);
    logic [OFF_W-1:0] byte_idx;
    logic [2:0]       bit_sel;

    generate
        if (PORT_W > 3) begin : g_wide
            assign byte_idx = OFF_W'(port[PORT_W-1:3]);
            assign bit_sel  = port[2:0];
        end else begin : g_narrow
            assign byte_idx = '0;
            assign bit_sel  = 3'(port);
        end
    endgenerate

    always_comb begin
        mask    = {12'b0, size_lanes(size_code)} << bit_sel;
        need_hi = |mask[15:8];
        off0    = OFF_W'(map_base) + byte_idx;
        off1    = off0 + OFF_W'(1);
        beyond  = (off0 > OFF_W'(limit)) || (need_hi && (off1 > OFF_W'(limit)));
    end
endmodule

// File: rtl/iop_seq.sv
module iop_seq
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] task_base,
    input  logic [LIM_W-1:0]  task_limit,
    input  logic              direct_done,
    input  logic              direct_allow,
    input  logic [15:0]       mask,
    input  logic              need_hi,
    input  logic [OFF_W-1:0]  off0,
    input  logic [OFF_W-1:0]  off1,
    input  logic              beyond,
    output logic [PORT_W-1:0] cap_port,
    output logic [1:0]        cap_size,
    output logic [LIM_W-1:0]  cap_limit,
    output logic [15:0]       map_base,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              resp_fault,
    output logic              idle
);
    st_e               st;
    logic [ADDR_W-1:0] cap_tbase;
    logic [7:0]        base_lo;
    logic [7:0]        map_b0;
    verdict_t          resp_q;
    logic [OFF_W-1:0]  rd_off;
    logic              deny_single;
    logic              deny_pair;

    always_comb begin
        case (st)
            ST_BASE_LO: rd_off = OFF_W'(MAP_FIELD_OFF);
            ST_BASE_HI: rd_off = OFF_W'(MAP_FIELD_OFF + 1);
            ST_MAP0:    rd_off = off0;
            ST_MAP1:    rd_off = off1;
            default:    rd_off = '0;
        endcase
        mem_rd_en   = (st == ST_BASE_LO) || (st == ST_BASE_HI) ||
                      (st == ST_MAP0)    || (st == ST_MAP1);
        mem_rd_addr = cap_tbase + ADDR_W'(rd_off);
        deny_single = |(mask[7:0] & mem_rdata);
        deny_pair   = |(mask & {mem_rdata, map_b0});
        idle        = (st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            resp_q    <= '0;
            cap_port  <= '0;
            cap_size  <= '0;
            cap_tbase <= '0;
            cap_limit <= '0;
            base_lo   <= '0;
            map_base  <= '0;
            map_b0    <= '0;
        end else begin
            resp_q <= '0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_port  <= req_port;
                        cap_size  <= req_size;
                        cap_tbase <= task_base;
                        cap_limit <= task_limit;
                        if (direct_done) begin
                            resp_q <= '{valid: 1'b1, allow: direct_allow, fault: !direct_allow};
                        end else begin
                            st <= ST_BASE_LO;
                        end
                    end
                end
                ST_BASE_LO: begin
                    if (mem_rvalid) begin
                        base_lo <= mem_rdata;
                        st      <= ST_BASE_HI;
                    end
                end
                ST_BASE_HI: begin
                    if (mem_rvalid) begin
                        map_base <= {mem_rdata, base_lo};
                        st       <= ST_MAP_CHK;
                    end
                end
                ST_MAP_CHK: begin
                    if (beyond) begin
                        resp_q <= '{valid: 1'b1, allow: 1'b0, fault: 1'b1};
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_MAP0;
                    end
                end
                ST_MAP0: begin
                    if (mem_rvalid) begin
                        if (need_hi) begin
                            map_b0 <= mem_rdata;
                            st     <= ST_MAP1;
                        end else begin
                            resp_q <= '{valid: 1'b1, allow: !deny_single, fault: deny_single};
                            st     <= ST_IDLE;
                        end
                    end
                end
                ST_MAP1: begin
                    if (mem_rvalid) begin
                        resp_q <= '{valid: 1'b1, allow: !deny_pair, fault: deny_pair};
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_allow = resp_q.allow;
    assign resp_fault = resp_q.fault;
endmodule

// File: rtl/iop_perm_check.sv
module iop_perm_check
    import iop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_iopl,
    input  logic [PORT_W-1:0] req_port,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] task_base,
    input  logic [15:0]       task_limit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              resp_fault
);
    logic              direct_done;
    logic              direct_allow;
    logic [PORT_W-1:0] cap_port;
    logic [1:0]        cap_size;
    logic [LIM_W-1:0]  cap_limit;
    logic [15:0]       map_base;
    logic [15:0]       span_mask;
    logic              need_hi;
    logic [OFF_W-1:0]  off0;
    logic [OFF_W-1:0]  off1;
    logic              beyond;
    logic              seq_idle;

    iop_priv_gate gate_i (
        .op           (op_e'(req_op)),
        .cpl          (req_cpl),
        .iopl         (req_iopl),
        .limit        (task_limit),
        .direct_done  (direct_done),
        .direct_allow (direct_allow)
    );

    iop_span_calc #(.PORT_W(PORT_W)) span_i (
        .port      (cap_port),
        .size_code (cap_size),
        .map_base  (map_base),
        .limit     (cap_limit),
        .mask      (span_mask),
        .need_hi   (need_hi),
        .off0      (off0),
        .off1      (off1),
        .beyond    (beyond)
    );

    iop_seq #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_port     (req_port),
        .req_size     (req_size),
        .task_base    (task_base),
        .task_limit   (task_limit),
        .direct_done  (direct_done),
        .direct_allow (direct_allow),
        .mask         (span_mask),
        .need_hi      (need_hi),
        .off0         (off0),
        .off1         (off1),
        .beyond       (beyond),
        .cap_port     (cap_port),
        .cap_size     (cap_size),
        .cap_limit    (cap_limit),
        .map_base     (map_base),
        .mem_rdata    (mem_rdata),
        .mem_rvalid   (mem_rvalid),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .resp_valid   (resp_valid),
        .resp_allow   (resp_allow),
        .resp_fault   (resp_fault),
        .idle         (seq_idle)
    );
endmodule

// File: rtl/iop_perm_check_chk.sv
module iop_perm_check_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_flag,
    input logic [1:0]        req_cpl,
    input logic [1:0]        req_iopl,
    input logic              seq_idle,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rvalid,
    input logic              resp_valid,
    input logic              resp_allow,
    input logic              resp_fault
);
    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ($countones({resp_allow, resp_fault}) == 1));

    // R8
    verdict_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> (!resp_allow && !resp_fault));

    // R8
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R2
    priv_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && req_valid && (req_cpl <= req_iopl)) |=>
            (resp_valid && resp_allow && !mem_rd_en));

    // R3
    flag_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && req_valid && req_is_flag && (req_cpl > req_iopl)) |=>
            (resp_valid && resp_fault && !mem_rd_en));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_rd_addr)));
endmodule

bind iop_perm_check iop_perm_check_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_flag (req_op[1]),
    .req_cpl     (req_cpl),
    .req_iopl    (req_iopl),
    .seq_idle    (seq_idle),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rvalid  (mem_rvalid),
    .resp_valid  (resp_valid),
    .resp_allow  (resp_allow),
    .resp_fault  (resp_fault)
);

// File: tb/iop_perm_check_tb_top.sv
module iop_perm_check_tb_top;
    localparam int AW = 12;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_cpl = '0;
    logic [1:0]    req_iopl = '0;
    logic [PW-1:0] req_port = '0;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] task_base = '0;
    logic [15:0]   task_limit = 16'hFFFF;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          resp_valid, resp_allow, resp_fault;

    logic [7:0] mem [0:4095];
    int lat = 0;
    int wait_cnt = 0;
    int rd_cnt = 0;
    int resp_cnt = 0;
    int total = 0;
    int bad = 0;

    localparam int TA = 'h100, TA_MAP = 'h80;
    localparam int TB = 'h400, TB_MAP = 'h90;
    localparam int TC = 'h800;

    always #5 clk = ~clk;

    iop_perm_check #(.ADDR_W(AW), .PORT_W(PW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_cpl(req_cpl), .req_iopl(req_iopl), .req_port(req_port),
        .req_size(req_size), .task_base(task_base), .task_limit(task_limit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .resp_fault(resp_fault)
    );

    // byte memory with adjustable latency
    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            wait_cnt   <= 0;
        end else if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
        end else if (mem_rd_en) begin
            if (wait_cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_rd_addr];
                wait_cnt   <= 0;
                rd_cnt     <= rd_cnt + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    always @(negedge clk) if (resp_valid) resp_cnt <= resp_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_req(input int op, input int cpl, input int iopl, input int port,
                           input int size, input int tb, input int lim, input int alt_tb,
                           output bit allow, output bit fault, output int cyc, output int nrd);
        int rd0;
        @(negedge clk);
        rd0        = rd_cnt;
        req_op     = 2'(op);
        req_cpl    = 2'(cpl);
        req_iopl   = 2'(iopl);
        req_port   = PW'(port);
        req_size   = 2'(size);
        task_base  = AW'(tb);
        task_limit = 16'(lim);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (alt_tb >= 0) task_base = AW'(alt_tb);
        cyc = 1;
        while (!resp_valid && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        allow = resp_allow;
        fault = resp_fault;
        nrd   = rd_cnt - rd0;
        if (!resp_valid) begin
            allow = 1'b0;
            fault = 1'b0;
        end
    endtask

    function automatic bit map_bit(int tb, int mapoff, int k);
        logic [7:0] b;
        b = mem[tb + mapoff + (k >> 3)];
        return b[k & 7];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a, f;
        int cyc, nrd;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        // task A: map offset 0x0080, patterned bitmap
        mem[TA + 102] = 8'(TA_MAP);
        mem[TA + 103] = 8'h00;
        for (int i = 0; i < 16; i++) mem[TA + TA_MAP + i] = 8'((i * 37 + 5) & 255);
        // task B: map offset 0x0090, ports 16..23 denied
        mem[TB + 102] = 8'(TB_MAP);
        mem[TB + 103] = 8'h00;
        mem[TB + TB_MAP + 2] = 8'hFF;
        // task C: map offset 0x0134 (high byte matters)
        mem[TC + 102] = 8'h34;
        mem[TC + 103] = 8'h01;
        mem[TC + 'h134] = 8'hFE;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!resp_valid && !resp_allow && !resp_fault && !mem_rd_en, "R1 reset outputs",
            {resp_valid, resp_allow, resp_fault, mem_rd_en}, 0);

        // privilege / operation sweep on a port the task A bitmap denies
        for (int op = 0; op < 4; op++)
            for (int cpl = 0; cpl < 4; cpl++)
                for (int io = 0; io < 4; io++) begin
                    run_req(op, cpl, io, 0, 0, TA, 'hFFFF, -1, a, f, cyc, nrd);
                    if (cpl <= io) begin
                        chk(a && !f && cyc == 1 && nrd == 0, "R2 direct grant",
                            {a, f, cyc[3:0], nrd[3:0]}, 'b10_0001_0000);
                    end else if (op >= 2) begin
                        chk(!a && f && cyc == 1 && nrd == 0, "R3 flag refusal",
                            {a, f, cyc[3:0], nrd[3:0]}, 'b01_0001_0000);
                    end else begin
                        chk(!a && f && nrd == 3, "R4 lookup on denied port",
                            {a, f, nrd[3:0]}, 'b01_0011);
                    end
                end

        // exhaustive port x size sweep, task A, varying latency
        for (int p = 0; p < 64; p++)
            for (int s = 0; s < 4; s++) begin
                int n;
                bit deny;
                bit span;
                n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                deny = 1'b0;
                for (int k = p; k < p + n; k++) deny |= map_bit(TA, TA_MAP, k);
                span = ((p & 7) + n) > 8;
                lat = (p + s) % 3;
                run_req(p & 1, 3, 0, p, s, TA, 'hFFFF, -1, a, f, cyc, nrd);
                if (span)
                    chk(a == !deny && f == deny, "R6 spanning bitmap verdict", {a, f}, {!deny, deny});
                else
                    chk(a == !deny && f == deny, "R5 bitmap verdict", {a, f}, {!deny, deny});
                chk(nrd == (span ? 4 : 3), "R4 lookup read count", nrd, span ? 4 : 3);
            end
        lat = 1;

        // R4: the high byte of the offset field is used
        run_req(0, 3, 0, 0, 0, TC, 'hFFFF, -1, a, f, cyc, nrd);
        chk(a && !f, "R4 wide offset port 0", {a, f}, 'b10);
        run_req(0, 3, 0, 1, 0, TC, 'hFFFF, -1, a, f, cyc, nrd);
        chk(!a && f, "R4 wide offset port 1", {a, f}, 'b01);

        // R7 limit boundaries on task B
        run_req(0, 3, 0, 62, 2, TB, TB_MAP + 8, -1, a, f, cyc, nrd);
        chk(a && !f && nrd == 4, "R7 limit covers second byte", {a, f, nrd[3:0]}, 'b10_0100);
        run_req(0, 3, 0, 62, 2, TB, TB_MAP + 7, -1, a, f, cyc, nrd);
        chk(!a && f && nrd == 2, "R7 second byte past limit", {a, f, nrd[3:0]}, 'b01_0010);
        run_req(1, 3, 0, 60, 2, TB, TB_MAP + 7, -1, a, f, cyc, nrd);
        chk(a && !f && nrd == 3, "R7 single byte at limit", {a, f, nrd[3:0]}, 'b10_0011);
        run_req(1, 3, 0, 60, 2, TB, TB_MAP + 6, -1, a, f, cyc, nrd);
        chk(!a && f && nrd == 2, "R7 single byte past limit", {a, f, nrd[3:0]}, 'b01_0010);
        run_req(0, 3, 0, 0, 0, TB, 102, -1, a, f, cyc, nrd);
        chk(!a && f && cyc == 1 && nrd == 0, "R7 offset field past limit",
            {a, f, cyc[3:0], nrd[3:0]}, 'b01_0001_0000);
        run_req(0, 3, 0, 0, 0, TB, 103, -1, a, f, cyc, nrd);
        chk(!a && f && nrd == 2, "R7 bitmap past limit 103", {a, f, nrd[3:0]}, 'b01_0010);
        run_req(0, 2, 1, 20, 0, TB, 'hFFFF, -1, a, f, cyc, nrd);
        chk(!a && f, "R5 task B denied range", {a, f}, 'b01);

        // R11: base switched during a lookup
        run_req(0, 3, 0, 0, 0, TA, 'hFFFF, TB, a, f, cyc, nrd);
        chk(!a && f, "R11 captured base A", {a, f}, 'b01);
        run_req(0, 3, 0, 0, 0, TB, 'hFFFF, TA, a, f, cyc, nrd);
        chk(a && !f, "R11 captured base B", {a, f}, 'b10);

        // R10: second request during a lookup is ignored
        begin
            int c0;
            lat = 3;
            @(negedge clk);
            c0 = resp_cnt;
            req_op = 2'b00; req_cpl = 2'd3; req_iopl = 2'd0; req_port = '0;
            req_size = 2'b00; task_base = AW'(TA); task_limit = 16'hFFFF;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            req_op = 2'b11; req_cpl = 2'd0; req_iopl = 2'd3;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (40) @(negedge clk);
            #1;
            chk(resp_cnt - c0 == 1, "R10 single verdict", resp_cnt - c0, 1);
        end
        lat = 0;
        run_req(1, 3, 0, 0, 0, TA, 'hFFFF, -1, a, f, cyc, nrd);
        chk(!a && f, "R10 verdict after ignored request", {a, f}, 'b01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule